// File: doc/BRIEF.md
# Eight-Pin Input Qualification Filter

This block conditions eight asynchronous input pins before internal logic sees them. Each pin has its own 2-bit mode. A pin can pass through a two-flop synchronizer only. It can pass through the synchronizer and then a debounce window of 3 or 6 samples. It can also bypass everything and feed the raw pin value straight to its output, for consumers that resynchronize internally.

The windowed modes take samples of the synchronized value on a shared sample strobe. One 8-bit period field, common to all eight pins, spaces the strobes. A windowed output moves to a new level only when every sample in its window holds that level. A window that holds mixed values leaves the output where it was. When a pin's mode changes, its sample history is discarded. The pin then needs a full window of fresh samples before its output can move.

Top module: `gpio_qual_group`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0 and every pin acts in synchronize-only mode, whatever `mode_sel` holds. The sample history and the held levels of all pins are cleared.
- R2: In mode 00, `pin_out[i]` equals `pin_async[i]` as sampled two rising clock edges earlier.
- R3: A mode value takes effect one clock edge after it is presented. In mode 11, `pin_out[i]` follows `pin_async[i]` combinationally, with no clock edge in between.
- R4: In mode 01 (3-sample window), with the period field at 0 and the input steady at a new level, the output changes on the 6th rising edge after the input changes, and not before.
- R5: In mode 10 (6-sample window), under the same conditions as R4, the output changes on the 9th rising edge after the input changes, and not before.
- R6: A windowed output keeps its previous value while its window holds both 0s and 1s. A pulse shorter than the window therefore never reaches the output.
- R7: A period field of 0 gives a sample on every clock. A value N greater than 0 gives one sample every 2N clocks. The strobe is shared by all eight pins.
- R8: When a pin's mode changes, its history is cleared. Its windowed output then holds until a whole window of samples taken after the change agrees.
- R9: Pin i takes its mode from bits [2i+1:2i] of `mode_sel`. Each pin operates independently of the mode of every other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 8 | Raw asynchronous pin levels |
| mode_sel | input | 16 | Per-pin mode, 2 bits per pin: 00 sync, 01 3-window, 10 6-window, 11 raw |
| sample_period | input | 8 | Shared sample spacing: 0 means every clock, N means every 2N clocks |
| pin_out | output | 8 | Conditioned pin levels |

## Verification
The case that is hardest to reach from the ports is a mode change that would produce a false edge if stale samples survived it. The newest three samples must be 1 while the six-deep window still disagrees, and at that very moment the pin must move to the 3-sample mode. The bench gets there by running in the 6-sample mode with the output low. It drives the pins high for exactly five edges, which puts three 1s in the history. It then switches to the 3-sample mode and drops the pins in the same step, and checks that the output stays low. A second hard case is the period divider, whose strobe phase cannot be seen at the ports. The bench checks it with pulse lengths that are rejected at any phase, and then with a sustained change that must eventually pass.

// File: rtl/gpio_qual_pkg.sv
package gpio_qual_pkg;

    typedef enum logic [1:0] {
        QM_SYNC = 2'b00,
        QM_WIN3 = 2'b01,
        QM_WIN6 = 2'b10,
        QM_RAW  = 2'b11
    } qual_mode_e;

    localparam int HIST_LEN  = 6;
    localparam int SHORT_WIN = 3;
    localparam int FILL_W    = $clog2(HIST_LEN + 1);

    typedef struct packed {
        logic [HIST_LEN-1:0] hist;
        logic [FILL_W-1:0]   fill;
        logic                held;
    } qual_state_t;

    typedef struct packed {
        logic agree;
        logic level;
    } qual_verdict_t;

    function automatic int window_depth(input qual_mode_e m);
        case (m)
            QM_WIN3: return SHORT_WIN;
            QM_WIN6: return HIST_LEN;
            default: return 0;
        endcase
    endfunction

    function automatic qual_verdict_t window_verdict(
        input logic [HIST_LEN-1:0] h,
        input logic [FILL_W-1:0]   fill,
        input qual_mode_e          m
    );
        qual_verdict_t       v;
        logic [HIST_LEN-1:0] mask;
        int                  need;
        need = window_depth(m);
        mask = '0;
        for (int k = 0; k < HIST_LEN; k++) begin
            if (k < need) mask[k] = 1'b1;
        end
        v.level = ((h & mask) == mask);
        v.agree = (need != 0) && (int'(fill) >= need) &&
                  (((h & mask) == mask) || ((h & mask) == '0));
        return v;
    endfunction

endpackage

// File: rtl/gpio_qual_divider.sv
module gpio_qual_divider #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period,
    output logic                strobe
);
    localparam int CNT_W = PERIOD_W + 1;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;

    assign strobe = (count == '0);

    always_comb begin
        if (period == '0) reload = '0;
        else              reload = {period, 1'b0} - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (strobe) count <= reload;
        else             count <= count - CNT_W'(1);
    end
endmodule

// File: rtl/gpio_qual_sync.sv
module gpio_qual_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_qual_pin.sv
module gpio_qual_pin
    import gpio_qual_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  qual_mode_e          mode_req,
    input  logic                sync_bit,
    input  logic                raw_bit,
    output logic                out_bit,
    output qual_mode_e          mode_eff,
    output logic [HIST_LEN-1:0] hist,
    output logic                held
);
    qual_state_t   st;
    qual_verdict_t verdict;

    always_comb verdict = window_verdict(st.hist, st.fill, mode_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_eff <= QM_SYNC;
            st       <= '0;
        end else begin
            mode_eff <= mode_req;
            if (mode_req != mode_eff) begin
                st.hist <= '0;
                st.fill <= '0;
            end else if (strobe) begin
                st.hist <= {st.hist[HIST_LEN-2:0], sync_bit};
                if (st.fill < FILL_W'(HIST_LEN)) st.fill <= st.fill + FILL_W'(1);
            end
            if (verdict.agree) st.held <= verdict.level;
        end
    end

    always_comb begin
        case (mode_eff)
            QM_SYNC: out_bit = sync_bit;
            QM_RAW:  out_bit = raw_bit;
            default: out_bit = st.held;
        endcase
    end

    assign hist = st.hist;
    assign held = st.held;
endmodule

// File: rtl/gpio_qual_group.sv
module gpio_qual_group
    import gpio_qual_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int PERIOD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pin_async,
    input  logic [2*NUM_PINS-1:0] mode_sel,
    input  logic [PERIOD_W-1:0]   sample_period,
    output logic [NUM_PINS-1:0]   pin_out
);
    logic                               sample_strobe;
    logic [NUM_PINS-1:0]                pin_sync;
    logic [NUM_PINS-1:0][HIST_LEN-1:0]  hist_w;
    logic [NUM_PINS-1:0]                held_w;
    logic [NUM_PINS-1:0][1:0]           mode_eff;

    gpio_qual_divider #(.PERIOD_W(PERIOD_W)) div_i (
        .clk    (clk),
        .rst    (rst),
        .period (sample_period),
        .strobe (sample_strobe)
    );

    gpio_qual_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_async),
        .q   (pin_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        qual_mode_e mode_e;
        gpio_qual_pin pin_i (
            .clk      (clk),
            .rst      (rst),
            .strobe   (sample_strobe),
            .mode_req (qual_mode_e'(mode_sel[2*i +: 2])),
            .sync_bit (pin_sync[i]),
            .raw_bit  (pin_async[i]),
            .out_bit  (pin_out[i]),
            .mode_eff (mode_e),
            .hist     (hist_w[i]),
            .held     (held_w[i])
        );
        assign mode_eff[i] = mode_e;
    end
endmodule

// File: rtl/gpio_qual_checker.sv
module gpio_qual_checker
    import gpio_qual_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int PERIOD_W = 8
) (
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_PINS-1:0]               pin_async,
    input logic [2*NUM_PINS-1:0]             mode_sel,
    input logic [PERIOD_W-1:0]               sample_period,
    input logic [NUM_PINS-1:0]               pin_out,
    input logic                              sample_strobe,
    input logic [NUM_PINS-1:0][HIST_LEN-1:0] hist_w,
    input logic [NUM_PINS-1:0]               held_w,
    input logic [NUM_PINS-1:0][1:0]          mode_eff
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pin_out == '0));

    assert_strobe_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (sample_period != '0 && sample_strobe) |=> !sample_strobe);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        assert_sync_delay_R2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && $past(mode_sel[2*i +: 2]) == 2'b00)
            |-> pin_out[i] == $past(pin_async[i], 2));

        assert_raw_follow_R3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mode_sel[2*i +: 2]) == 2'b11)
            |-> pin_out[i] == pin_async[i]);

        assert_rise_agree_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(held_w[i]) |-> $past(hist_w[i][2:0]) == 3'b111);

        assert_fall_agree_R6: assert property (@(posedge clk) disable iff (rst)
            $fell(held_w[i]) |-> $past(hist_w[i][2:0]) == 3'b000);

        assert_hist_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (mode_sel[2*i +: 2] != mode_eff[i]) |=> hist_w[i] == '0);
    end
endmodule

bind gpio_qual_group gpio_qual_checker #(
    .NUM_PINS (NUM_PINS),
    .PERIOD_W (PERIOD_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .pin_async     (pin_async),
    .mode_sel      (mode_sel),
    .sample_period (sample_period),
    .pin_out       (pin_out),
    .sample_strobe (sample_strobe),
    .hist_w        (hist_w),
    .held_w        (held_w),
    .mode_eff      (mode_eff)
);

// File: tb/gpio_qual_group_tb.sv
module gpio_qual_group_tb_top;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_async = 8'hFF;
    logic [15:0] mode_sel = 16'hFFFF;
    logic [7:0]  sample_period = 8'd0;
    logic [7:0]  pin_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    gpio_qual_group dut_i (
        .clk           (clk),
        .rst           (rst),
        .pin_async     (pin_async),
        .mode_sel      (mode_sel),
        .sample_period (sample_period),
        .pin_out       (pin_out)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pin_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input logic [15:0] m, input logic [7:0] p, input logic [7:0] per);
        mode_sel = m; pin_async = p; sample_period = per;
        step(20);
    endtask

    task automatic t_reset;
        step(3);
        rst = 1'b0;
        check("R1 outputs clear after reset", pin_out, 8'h00);
        step(1);
        check("R3 raw mode after one edge", pin_out, 8'hFF);
    endtask

    task automatic t_sync_only;
        settle(16'h0000, 8'h00, 8'd0);
        pin_async = 8'hA5;
        step(1);
        check("R2 sync one edge", pin_out, 8'h00);
        step(1);
        check("R2 sync two edges", pin_out, 8'hA5);
    endtask

    task automatic t_raw;
        settle(16'hFFFF, 8'h00, 8'd0);
        pin_async = 8'h3C; #1;
        check("R3 raw follow a", pin_out, 8'h3C);
        pin_async = 8'hC3; #1;
        check("R3 raw follow b", pin_out, 8'hC3);
    endtask

    task automatic t_win3;
        settle(16'h5555, 8'h00, 8'd0);
        pin_async = 8'hFF;
        step(5);
        check("R4 win3 rise not before 6", pin_out, 8'h00);
        step(1);
        check("R4 win3 rise at 6", pin_out, 8'hFF);
        step(4);
        pin_async = 8'h00;
        step(5);
        check("R4 win3 fall not before 6", pin_out, 8'hFF);
        step(1);
        check("R4 win3 fall at 6", pin_out, 8'h00);
    endtask

    task automatic t_win6;
        settle(16'hAAAA, 8'h00, 8'd0);
        pin_async = 8'hFF;
        step(8);
        check("R5 win6 not before 9", pin_out, 8'h00);
        step(1);
        check("R5 win6 at 9", pin_out, 8'hFF);
    endtask

    task automatic t_glitch;
        settle(16'h5555, 8'hFF, 8'd0);
        pin_async = 8'h00; step(2);
        pin_async = 8'hFF; step(10);
        check("R6 win3 rejects 2-cycle pulse", pin_out, 8'hFF);
        settle(16'hAAAA, 8'hFF, 8'd0);
        pin_async = 8'h00; step(5);
        pin_async = 8'hFF; step(12);
        check("R6 win6 rejects 5-cycle pulse", pin_out, 8'hFF);
    endtask

    task automatic t_period;
        settle(16'h5555, 8'hFF, 8'd2);
        pin_async = 8'h00; step(8);
        check("R7 period 2 too few samples", pin_out, 8'hFF);
        step(40);
        check("R7 period 2 sustained level passes", pin_out, 8'h00);
    endtask

    task automatic t_mode_change;
        settle(16'hAAAA, 8'h00, 8'd0);
        pin_async = 8'hFF;
        step(5);
        mode_sel = 16'h5555; pin_async = 8'h00;
        step(10);
        check("R8 stale history discarded", pin_out, 8'h00);
    endtask

    task automatic t_mixed;
        settle(16'h00FF, 8'h00, 8'd0);
        pin_async = 8'hFF; #1;
        check("R9 low pins raw, high pins sync", pin_out, 8'h0F);
        step(2);
        check("R9 high pins after sync", pin_out, 8'hFF);
    endtask

    initial begin
        #(CLK_NS * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_sync_only();
        t_raw();
        t_win3();
        t_win6();
        t_glitch();
        t_period();
        t_mode_change();
        t_mixed();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule